// File: doc/BRIEF.md
# DMA Request Controller With Two Acknowledge Styles

This block drives the active-low DMA request line that tells a host processor when to move data through a memory card bridge's data buffer. It fills the transmit buffer during card writes and drains the receive buffer during card reads. It looks at four things: whether a data phase is running, which direction that phase moves data, whether the transmit buffer is short of data, and whether the receive buffer holds data. It also watches host accesses to the data buffer word address.

A control bit picks one of two handshake styles. In paced mode the acknowledge input is ignored. The request drops after each host access to the data buffer and comes back a fixed number of clocks later if it is still needed. In counted mode a transfer length is loaded when a data command starts. The request then stays asserted whatever the buffer status, and each acknowledge pulse counts one transfer until the length is used up.

Top module: `dma_req_ctrl`

## Requirements
- R1: `dreq_n` is active low. Synchronous reset forces it to 1 and clears the remaining-transfer count. After reset and with no `cmd_start`, counted mode (`ack_mode`=1) raises no request even when a buffer asks for one.
- R2: Transmit, paced mode (`dir_tx`=1, `ack_mode`=0): with `phase_active`=1 and `tx_need`=1, `dreq_n` goes low one clock later. When `tx_need` is 0, `dreq_n` returns to 1 one clock later.
- R3: Receive, paced mode (`dir_tx`=0): with `phase_active`=1 and `rx_avail`=1, `dreq_n` goes low one clock later. Once the buffer has been emptied (`rx_avail`=0) or the phase has ended, it stays 1.
- R4: While `phase_active` is 0, `dreq_n` is 1 from the next clock on, in both modes.
- R5: Paced mode: a host access (`bus_strobe`=1) at the data buffer word address `bus_addr`=3'b010 while requesting drives `dreq_n` to 1 on the next clock.
- R6: Paced mode: after such an access, `dreq_n` stays 1 for exactly 4 clocks. It goes low again on the clock after that if the buffer still asks for service, and otherwise stays 1.
- R7: Paced mode: `dack` has no effect, and strobes at any address other than 3'b010 have no effect. An active request stays low through them.
- R8: Counted mode: a `cmd_start` pulse loads `xfer_len`. The request then asserts when the buffer asks for service and stays low whatever `tx_need`, `rx_avail` or `bus_strobe` do, until `xfer_len` pulses of `dack` have been seen. It drops on the clock after the last one and stays 1 until the next `cmd_start`.
- R9: Counted mode with `xfer_len`=0 at `cmd_start` raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ack_mode | input | 1 | 0 = paced mode (acknowledge ignored), 1 = counted mode |
| dir_tx | input | 1 | 1 = transfer to the card, 0 = transfer from the card |
| phase_active | input | 1 | Data command has gone to the card and is still running |
| tx_need | input | 1 | Transmit buffer does not hold enough data |
| rx_avail | input | 1 | Receive buffer holds data |
| cmd_start | input | 1 | One-clock pulse when a data command starts; loads the length |
| xfer_len | input | LEN_W | Number of acknowledged transfers in counted mode |
| bus_strobe | input | 1 | One-clock pulse per completed host access |
| bus_addr | input | ADDR_W | Word address of the host access |
| dack | input | 1 | DMA acknowledge pulse, one per transfer |
| dreq_n | output | 1 | DMA request to the host, active low |

## Verification
The checker watches some rules on every clock. A data-address hit while requesting in paced mode always drops the request. The request never comes back inside the 4-clock window that follows. An idle phase always silences the request. An active request survives anything except a data-address hit or a lost buffer condition in paced mode, and anything except an acknowledge in counted mode. Some behaviour only the directed scenarios can show. These are the exact clock on which the request returns, the acknowledge count reaching the loaded length, a zero length, and the reset-cleared count.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } dreq_state_e;

    typedef struct packed {
        logic active;
        logic dir_tx;
        logic tx_need;
        logic rx_avail;
    } buf_status_t;

    // Buffer side asks for host service in the current direction.
    function automatic logic service_wanted(buf_status_t s);
        return s.active && (s.dir_tx ? s.tx_need : s.rx_avail);
    endfunction

endpackage

// File: rtl/dreq_gap_timer.sv
module dreq_gap_timer #(
    parameter int GAP_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(GAP_CLKS + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(GAP_CLKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_VAL;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dreq_xfer_count.sv
module dreq_xfer_count #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             dec,
    output logic             rem_zero,
    output logic             rem_last
);
    logic [LEN_W-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst)
            rem <= '0;
        else if (load)
            rem <= len;
        else if (dec && rem != '0)
            rem <= rem - 1'b1;
    end

    assign rem_zero = (rem == '0);
    assign rem_last = (rem == LEN_W'(1));
endmodule

// File: rtl/dreq_fsm.sv
module dreq_fsm
    import dreq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack_mode,
    input  logic restart,
    input  logic active,
    input  logic want,
    input  logic buf_hit,
    input  logic dack,
    input  logic gap_expired,
    input  logic rem_zero,
    input  logic rem_last,
    output logic gap_load,
    output logic cnt_dec,
    output logic in_req
);
    dreq_state_e state, nxt;

    always_comb begin
        nxt      = state;
        gap_load = 1'b0;
        cnt_dec  = 1'b0;
        if (restart || !active) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (want && (!ack_mode || !rem_zero))
                        nxt = ST_REQ;
                end
                ST_REQ: begin
                    if (ack_mode) begin
                        if (dack) begin
                            cnt_dec = 1'b1;
                            if (rem_last)
                                nxt = ST_IDLE;
                        end
                    end else if (buf_hit) begin
                        nxt      = ST_GAP;
                        gap_load = 1'b1;
                    end else if (!want) begin
                        nxt = ST_IDLE;
                    end
                end
                ST_GAP: begin
                    if (gap_expired)
                        nxt = (want && !ack_mode) ? ST_REQ : ST_IDLE;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    assign in_req = (state == ST_REQ);
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import dreq_pkg::*;
#(
    parameter int              ADDR_W    = 3,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 3'b010,
    parameter int              GAP_CLKS  = 4,
    parameter int              LEN_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_mode,
    input  logic              dir_tx,
    input  logic              phase_active,
    input  logic              tx_need,
    input  logic              rx_avail,
    input  logic              cmd_start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              bus_strobe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              dack,
    output logic              dreq_n
);
    buf_status_t bstat;
    logic want, buf_hit, gap_load, gap_expired, cnt_dec, rem_zero, rem_last, in_req;

    assign bstat   = '{active: phase_active, dir_tx: dir_tx, tx_need: tx_need, rx_avail: rx_avail};
    assign want    = service_wanted(bstat);
    assign buf_hit = bus_strobe && (bus_addr == DATA_ADDR);

    dreq_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .expired (gap_expired)
    );

    dreq_xfer_count #(.LEN_W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd_start),
        .len      (xfer_len),
        .dec      (cnt_dec),
        .rem_zero (rem_zero),
        .rem_last (rem_last)
    );

    dreq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ack_mode    (ack_mode),
        .restart     (cmd_start),
        .active      (phase_active),
        .want        (want),
        .buf_hit     (buf_hit),
        .dack        (dack),
        .gap_expired (gap_expired),
        .rem_zero    (rem_zero),
        .rem_last    (rem_last),
        .gap_load    (gap_load),
        .cnt_dec     (cnt_dec),
        .in_req      (in_req)
    );

    assign dreq_n = ~in_req;
endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk #(
    parameter int              ADDR_W    = 3,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 3'b010,
    parameter int              GAP_CLKS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              ack_mode,
    input logic              dir_tx,
    input logic              phase_active,
    input logic              tx_need,
    input logic              rx_avail,
    input logic              cmd_start,
    input logic              bus_strobe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              dack,
    input logic              dreq_n
);
    logic want, hit, paced_drop;
    logic [7:0] gap_win;

    assign want       = phase_active && (dir_tx ? tx_need : rx_avail);
    assign hit        = bus_strobe && (bus_addr == DATA_ADDR);
    assign paced_drop = !ack_mode && !dreq_n && hit && phase_active && !cmd_start;

    // Window tracker: clocks left in which the request must stay off.
    always_ff @(posedge clk) begin
        if (rst || cmd_start || !phase_active || ack_mode)
            gap_win <= '0;
        else if (paced_drop)
            gap_win <= 8'(GAP_CLKS);
        else if (gap_win != '0)
            gap_win <= gap_win - 1'b1;
    end

    a_r4_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !phase_active |=> dreq_n);

    a_r5_hit_drops: assert property (@(posedge clk) disable iff (rst)
        paced_drop |=> dreq_n);

    a_r6_gap_held: assert property (@(posedge clk) disable iff (rst)
        (gap_win != '0) |-> dreq_n);

    a_r7_paced_keep: assert property (@(posedge clk) disable iff (rst)
        (!ack_mode && !dreq_n && phase_active && !cmd_start && want && !hit) |=> !dreq_n);

    a_r8_counted_hold: assert property (@(posedge clk) disable iff (rst)
        (ack_mode && !dreq_n && phase_active && !cmd_start && !dack) |=> !dreq_n);
endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_ADDR (DATA_ADDR),
    .GAP_CLKS  (GAP_CLKS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ack_mode     (ack_mode),
    .dir_tx       (dir_tx),
    .phase_active (phase_active),
    .tx_need      (tx_need),
    .rx_avail     (rx_avail),
    .cmd_start    (cmd_start),
    .bus_strobe   (bus_strobe),
    .bus_addr     (bus_addr),
    .dack         (dack),
    .dreq_n       (dreq_n)
);

// File: tb/tb_dma_req_ctrl.sv
`timescale 1ns/1ps
module tb_dma_req_ctrl;
    logic       clk = 1'b0;
    logic       rst, ack_mode, dir_tx, phase_active, tx_need, rx_avail;
    logic       cmd_start, bus_strobe, dack;
    logic [7:0] xfer_len;
    logic [2:0] bus_addr;
    logic       dreq_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_req_ctrl dut (
        .clk(clk), .rst(rst), .ack_mode(ack_mode), .dir_tx(dir_tx),
        .phase_active(phase_active), .tx_need(tx_need), .rx_avail(rx_avail),
        .cmd_start(cmd_start), .xfer_len(xfer_len), .bus_strobe(bus_strobe),
        .bus_addr(bus_addr), .dack(dack), .dreq_n(dreq_n)
    );

    task automatic step(); @(negedge clk); endtask

    task automatic expect_req(input logic exp, input string tag);
        checks++;
        if (dreq_n !== exp) begin
            errors++;
            $display("FAIL %s: dreq_n=%b expected %b at %0t", tag, dreq_n, exp, $time);
        end
    endtask

    task automatic quiet();
        ack_mode = 0; dir_tx = 0; phase_active = 0; tx_need = 0; rx_avail = 0;
        cmd_start = 0; xfer_len = 0; bus_strobe = 0; bus_addr = 0; dack = 0;
        step(); step();
    endtask

    task automatic do_reset();
        rst = 1; quiet(); rst = 0; step();
    endtask

    task automatic access(input logic [2:0] a);
        bus_strobe = 1; bus_addr = a; step(); bus_strobe = 0; bus_addr = 0;
    endtask

    task automatic pulse_dack();
        dack = 1; step(); dack = 0;
    endtask

    task automatic t_reset();
        do_reset();
        expect_req(1'b1, "R1 reset inactive");
        ack_mode = 1; phase_active = 1; dir_tx = 1; tx_need = 1;
        step(); step();
        expect_req(1'b1, "R1 count cleared by reset");
        quiet();
    endtask

    task automatic t_tx_paced();
        do_reset();
        dir_tx = 1; phase_active = 1; tx_need = 1;
        step();
        expect_req(1'b0, "R2 tx request asserts");
        tx_need = 0; step();
        expect_req(1'b1, "R2 tx buffer has enough");
        step();
        expect_req(1'b1, "R2 tx stays inactive");
        quiet();
    endtask

    task automatic t_rx_gap();
        do_reset();
        dir_tx = 0; phase_active = 1; rx_avail = 1;
        step();
        expect_req(1'b0, "R3 rx request asserts");
        access(3'b011);
        expect_req(1'b0, "R7 other address ignored");
        pulse_dack();
        expect_req(1'b0, "R7 dack ignored in paced mode");
        access(3'b010);
        expect_req(1'b1, "R5 drop after data access");
        for (int i = 0; i < 3; i++) begin
            step(); expect_req(1'b1, "R6 gap held");
        end
        step();
        expect_req(1'b0, "R6 rearm after 4 clocks");
        // Drain: last access empties the buffer, no rearm.
        access(3'b010);
        rx_avail = 0;
        for (int i = 0; i < 5; i++) step();
        expect_req(1'b1, "R3 rx drained stays inactive");
        rx_avail = 1; phase_active = 0; step(); step();
        expect_req(1'b1, "R4 phase ended no request");
        quiet();
    endtask

    task automatic t_counted(input logic tx, input logic [7:0] n);
        do_reset();
        ack_mode = 1; dir_tx = tx; phase_active = 1; tx_need = tx; rx_avail = !tx;
        xfer_len = n; cmd_start = 1; step(); cmd_start = 0; xfer_len = 0;
        step();
        expect_req(1'b0, "R8 counted request asserts");
        tx_need = 0; rx_avail = 0;
        access(3'b010);
        expect_req(1'b0, "R8 held despite buffer and access");
        for (int i = 1; i < n; i++) begin
            pulse_dack();
            expect_req(1'b0, "R8 held before last dack");
        end
        pulse_dack();
        expect_req(1'b1, "R8 released after last dack");
        tx_need = tx; rx_avail = !tx;
        step(); step(); step();
        expect_req(1'b1, "R8 no request until next start");
        quiet();
    endtask

    task automatic t_zero_len();
        do_reset();
        ack_mode = 1; dir_tx = 0; phase_active = 1; rx_avail = 1;
        xfer_len = 0; cmd_start = 1; step(); cmd_start = 0;
        step(); step();
        expect_req(1'b1, "R9 zero length no request");
        quiet();
    endtask

    initial begin
        rst = 1;
        quiet();
        t_reset();
        t_tx_paced();
        t_rx_gap();
        t_counted(1'b1, 8'd3);
        t_counted(1'b0, 8'd2);
        t_zero_len();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule